// File: doc/BRIEF.md
# Reset Domain Isolation and Status Controller

This block sits between the chip's reset sources and two reset domains: the core logic and an Ethernet switch domain that can keep running through most resets. A power-on level and an external warm-reset level come in asynchronously. Four more reset requests come in as single-cycle pulses on the core clock: emulation warm, watchdog, software global cold and software global warm. Each pulse opens a reset window of fixed length. The core reset follows every source. The switch reset follows power-on in every case. For every other source, the switch reset follows only when isolation is not in force. Isolation is in force when the software isolation bit is set and the switch clock is taken from the SERDES.

The block holds three configuration registers. The first is the isolation bit. The second is a switch-side word that survives isolated resets. The third is a core-side word that every reset clears. The block also drives the reset-status pad, with an output enable and a pull enable, and it samples a boot-mode strap. The strap chooses whether non-watchdog pulse resets are also shown on the pad.

Top module: `rstiso_top`

## Requirements
- R1: While porN is low, coreRstN and swRstN are low, isoEn, swCfg and coreCfg read zero, and statusOe and statusPullEn are 0.
- R2: While extRstN is low, coreRstN is low. swRstN is low unless isoEn=1 and clkSelSerdes=1, in which case it stays high.
- R3: A one-cycle pulse on any srcPulse bit asserts coreRstN low from the edge that samples it. srcPulse bit 0 is emulation warm, bit 1 is watchdog, bit 2 is software cold and bit 3 is software warm.
- R4: During a pulse reset, swRstN goes low unless isoEn=1 and clkSelSerdes=1 when the pulse is taken, in which case swRstN stays high.
- R5: isoEn is cleared only by power-on. swCfg keeps its value through any reset that leaves swRstN high, and it reads zero after a reset that drove swRstN low.
- R6: coreCfg reads zero after every reset.
- R7: With the pad enabled, statusOut is 1 when no reset window is open, and it is 0 during a watchdog (bit 1) reset window whatever the strap.
- R8: During a bit 0, 2 or 3 reset window, statusOut is 0 if the latched strap is 0 and 1 if the latched strap is 1.
- R9: While porN or extRstN is low, statusOe=0 and statusPullEn=0. Otherwise both are 1.
- R10: The strap value seen on bootStrap when porN or extRstN is released is the one that is kept.
- R11: coreRstN rises on the second core-clock edge after the RST_CYCLES-cycle window ends, which is RST_CYCLES+2 edges after the pulse is sampled.
- R12: A configuration write (cfgWe=1) made while a reset window is open, or while porN or extRstN is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| swClk | input | 1 | Switch domain clock |
| porN | input | 1 | Power-on reset level, active low, asynchronous |
| extRstN | input | 1 | External warm reset level, active low, asynchronous |
| srcPulse | input | 4 | One-hot reset request pulses: emulation warm, watchdog, software cold, software warm |
| clkSelSerdes | input | 1 | 1 when the switch clock comes from the SERDES |
| bootStrap | input | 1 | Boot-mode strap bit |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIso | input | 1 | Isolation bit write data |
| cfgSwData | input | CFG_W | Switch-side word write data |
| cfgCoreData | input | CFG_W | Core-side word write data |
| coreRstN | output | 1 | Core reset, active low, synchronized to clk |
| swRstN | output | 1 | Switch reset, active low, synchronized to swClk |
| isoEn | output | 1 | Current isolation bit |
| swCfg | output | CFG_W | Switch-side retained word |
| coreCfg | output | CFG_W | Core-side word |
| statusOut | output | 1 | Reset-status pad value |
| statusOe | output | 1 | Reset-status pad output enable |
| statusPullEn | output | 1 | Reset-status pad internal pull enable |

## Verification
The checks assume that srcPulse has at most one bit set and is high for a single core-clock cycle. They also assume that bootStrap changes only while porN or extRstN is held low, and that clkSelSerdes is steady for the whole of a reset window. The stimulus sets the strap and the clock select before each reset and raises each request pulse for exactly one cycle. Each request is raised alone, from the falling edge of the core clock.

// File: rtl/rstiso_pkg.sv
package rstiso_pkg;
  localparam int SRC_N = 4;
  localparam int SRC_EMU = 0;
  localparam int SRC_WDOG = 1;
  localparam int SRC_SWCOLD = 2;
  localparam int SRC_SWWARM = 3;

  typedef struct packed {
    logic coreHold;   // pulse reset window open
    logic swHold;     // window open and switch domain included
    logic swClr;      // switch domain under reset (pulse or external)
    logic wdShow;     // status pad shows watchdog reset
    logic otherShow;  // status pad shows other pulse reset
    logic padFloat;   // hardware reset level: pad in high impedance
    logic cfgLock;    // configuration writes blocked
  } ctrlStrb_t;
endpackage

// File: rtl/rstiso_sync.sv
module rstiso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic reqN,
  output logic rstN
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge reqN) begin
    if (!reqN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], 1'b1};
  end

  assign rstN = shiftQ[STAGES-1];

  // R11
  early_release_chk: assert property (@(posedge clk) disable iff (!reqN)
    $rose(rstN) |-> $past(reqN));
endmodule

// File: rtl/rstiso_ctrl.sv
module rstiso_ctrl
  import rstiso_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             hwRstN,
  input  logic [SRC_N-1:0] srcPulse,
  input  logic             clkSelSerdes,
  input  logic             bootStrap,
  input  logic             isoQ,
  output ctrlStrb_t        strb
);
  logic [CW-1:0] cntQ;
  logic wdHitQ, otherHitQ, swHitQ, strapQ;
  logic active, isoEff;

  assign active = (cntQ != '0);
  assign isoEff = isoQ & clkSelSerdes;

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      cntQ      <= '0;
      wdHitQ    <= 1'b0;
      otherHitQ <= 1'b0;
      swHitQ    <= 1'b0;
    end else if (|srcPulse) begin
      cntQ      <= CW'(RST_CYCLES);
      wdHitQ    <= srcPulse[SRC_WDOG];
      otherHitQ <= srcPulse[SRC_EMU] | srcPulse[SRC_SWCOLD] | srcPulse[SRC_SWWARM];
      swHitQ    <= !isoEff;
    end else if (active) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  // strap follows the pin while a hardware reset is held, frozen at release
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)         strapQ <= bootStrap;
    else if (!extRstN) strapQ <= bootStrap;
  end

  always_comb begin
    strb.coreHold  = active;
    strb.swHold    = active & swHitQ;
    strb.swClr     = (active & swHitQ) | (!extRstN & !isoEff);
    strb.wdShow    = active & wdHitQ;
    strb.otherShow = active & otherHitQ & !strapQ;
    strb.padFloat  = !hwRstN;
    strb.cfgLock   = active | !hwRstN;
  end

  // R3
  onehot_req_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    $onehot0(srcPulse));
  // R3
  window_load_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (|srcPulse) |=> (cntQ == CW'(RST_CYCLES)));
  // R7
  wdog_show_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    srcPulse[SRC_WDOG] |=> (strb.wdShow && !strb.otherShow));
endmodule

// File: rtl/rstiso_dp.sv
module rstiso_dp
  import rstiso_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             hwRstN,
  input  ctrlStrb_t        strb,
  input  logic             cfgWe,
  input  logic             cfgIso,
  input  logic [CFG_W-1:0] cfgSwData,
  input  logic [CFG_W-1:0] cfgCoreData,
  output logic             isoQ,
  output logic [CFG_W-1:0] swCfgQ,
  output logic [CFG_W-1:0] coreCfgQ,
  output logic             statusOut,
  output logic             statusOe,
  output logic             statusPullEn
);
  logic wrOk;
  assign wrOk = cfgWe & !strb.cfgLock;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)     isoQ <= 1'b0;
    else if (wrOk) isoQ <= cfgIso;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           swCfgQ <= '0;
    else if (strb.swClr) swCfgQ <= '0;
    else if (wrOk)       swCfgQ <= cfgSwData;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN)            coreCfgQ <= '0;
    else if (strb.coreHold) coreCfgQ <= '0;
    else if (wrOk)          coreCfgQ <= cfgCoreData;
  end

  assign statusOe     = !strb.padFloat;
  assign statusPullEn = !strb.padFloat;
  assign statusOut    = strb.padFloat | !(strb.wdShow | strb.otherShow);

  // R5
  iso_keep_chk: assert property (@(posedge clk) disable iff (!porN)
    !cfgWe |=> $stable(isoQ));
  // R12
  locked_write_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (strb.coreHold && !strb.swClr) |=> $stable(swCfgQ));
endmodule

// File: rtl/rstiso_top.sv
module rstiso_top
  import rstiso_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             swClk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic [3:0]       srcPulse,
  input  logic             clkSelSerdes,
  input  logic             bootStrap,
  input  logic             cfgWe,
  input  logic             cfgIso,
  input  logic [CFG_W-1:0] cfgSwData,
  input  logic [CFG_W-1:0] cfgCoreData,
  output logic             coreRstN,
  output logic             swRstN,
  output logic             isoEn,
  output logic [CFG_W-1:0] swCfg,
  output logic [CFG_W-1:0] coreCfg,
  output logic             statusOut,
  output logic             statusOe,
  output logic             statusPullEn
);
  ctrlStrb_t strb;
  logic hwRstN, coreReqN, swReqN;

  assign hwRstN   = porN & extRstN;
  assign coreReqN = hwRstN & !strb.coreHold;
  assign swReqN   = porN & !strb.swClr;   // power-on bypasses all gating

  rstiso_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .porN(porN), .extRstN(extRstN), .hwRstN(hwRstN),
    .srcPulse(srcPulse), .clkSelSerdes(clkSelSerdes), .bootStrap(bootStrap),
    .isoQ(isoEn), .strb(strb)
  );

  rstiso_dp #(.CFG_W(CFG_W)) u_dp (
    .clk(clk), .porN(porN), .hwRstN(hwRstN), .strb(strb),
    .cfgWe(cfgWe), .cfgIso(cfgIso), .cfgSwData(cfgSwData), .cfgCoreData(cfgCoreData),
    .isoQ(isoEn), .swCfgQ(swCfg), .coreCfgQ(coreCfg),
    .statusOut(statusOut), .statusOe(statusOe), .statusPullEn(statusPullEn)
  );

  rstiso_sync #(.STAGES(2)) u_coreSync (.clk(clk),   .reqN(coreReqN), .rstN(coreRstN));
  rstiso_sync #(.STAGES(2)) u_swSync   (.clk(swClk), .reqN(swReqN),   .rstN(swRstN));

  // R4
  iso_switch_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.coreHold && !strb.swHold) |-> (swReqN || !extRstN));
endmodule

// File: tb/rstiso_top_tb.sv
module rstiso_top_tb;
  localparam int RSTC = 16;
  localparam int CW = 8;

  logic clk = 0, swClk = 0;
  logic porN = 0, extRstN = 1, clkSelSerdes = 0, bootStrap = 0;
  logic [3:0] srcPulse = '0;
  logic cfgWe = 0, cfgIso = 0;
  logic [CW-1:0] cfgSwData = '0, cfgCoreData = '0;
  logic coreRstN, swRstN, isoEn, statusOut, statusOe, statusPullEn;
  logic [CW-1:0] swCfg, coreCfg;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #15 swClk = ~swClk;

  rstiso_top #(.RST_CYCLES(RSTC), .CFG_W(CW)) u_dut (
    .clk(clk), .swClk(swClk), .porN(porN), .extRstN(extRstN), .srcPulse(srcPulse),
    .clkSelSerdes(clkSelSerdes), .bootStrap(bootStrap), .cfgWe(cfgWe), .cfgIso(cfgIso),
    .cfgSwData(cfgSwData), .cfgCoreData(cfgCoreData), .coreRstN(coreRstN), .swRstN(swRstN),
    .isoEn(isoEn), .swCfg(swCfg), .coreCfg(coreCfg), .statusOut(statusOut),
    .statusOe(statusOe), .statusPullEn(statusPullEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic iso, input logic [CW-1:0] sw, input logic [CW-1:0] core);
    cfgWe = 1; cfgIso = iso; cfgSwData = sw; cfgCoreData = core;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // power-on with strap, then program configuration
  task automatic powerUp(input logic iso, input logic sel, input logic strap);
    @(negedge clk);
    porN = 0; bootStrap = strap; clkSelSerdes = sel;
    waitCyc(3);
    chk("R1 coreRstN", coreRstN, 0);
    chk("R1 swRstN", swRstN, 0);
    chk("R1 cfg", {isoEn, swCfg, coreCfg}, 0);
    chk("R9 oe/pull por", {statusOe, statusPullEn}, 0);
    porN = 1;
    waitCyc(8);
    chk("R7 idle status", {statusOe, statusPullEn, statusOut}, 3'b111);
    cfgWrite(iso, 8'hA5, 8'h3C);
    chk("R5 isoEn written", isoEn, iso);
  endtask

  task automatic pulseCase(input int kind, input logic iso, input logic sel, input logic strap);
    int k;
    bit isoEff;
    isoEff = iso & sel;
    powerUp(iso, sel, strap);
    srcPulse = 4'b1 << kind;
    @(negedge clk);
    srcPulse = '0;
    chk("R3 coreRstN low", coreRstN, 0);
    chk("R4 swRstN", swRstN, isoEff ? 1 : 0);
    chk("R7/R8 status", statusOut, (kind == 1 || !strap) ? 0 : 1);
    // attempted write while the window is open
    cfgWe = 1; cfgIso = ~iso; cfgSwData = 8'hFF; cfgCoreData = 8'hFF;
    @(negedge clk);
    cfgWe = 0;
    k = 1;
    while (coreRstN == 0 && k < 100) begin @(negedge clk); k++; end
    chk("R11 release edge", k, RSTC + 2);
    waitCyc(8);
    chk("R4 swRstN released", swRstN, 1);
    chk("R7 status after", statusOut, 1);
    chk("R12/R5 isoEn", isoEn, iso);
    chk("R5/R12 swCfg", swCfg, isoEff ? 8'hA5 : 0);
    chk("R6 coreCfg", coreCfg, 0);
  endtask

  task automatic extCase(input logic iso, input logic sel, input logic strap);
    bit isoEff;
    isoEff = iso & sel;
    powerUp(iso, sel, strap);
    extRstN = 0;
    bootStrap = ~strap;
    waitCyc(3);
    chk("R2 coreRstN", coreRstN, 0);
    chk("R2 swRstN", swRstN, isoEff ? 1 : 0);
    chk("R9 oe/pull ext", {statusOe, statusPullEn}, 0);
    cfgWrite(~iso, 8'h11, 8'h22);
    extRstN = 1;
    waitCyc(8);
    chk("R12 isoEn", isoEn, iso);
    chk("R5 swCfg ext", swCfg, isoEff ? 8'hA5 : 0);
    chk("R6 coreCfg ext", coreCfg, 0);
    chk("R9 oe/pull after", {statusOe, statusPullEn}, 2'b11);
    srcPulse = 4'b0001;
    @(negedge clk);
    srcPulse = '0;
    chk("R10 strap relatched", statusOut, strap ? 0 : 1);
    waitCyc(RSTC + 8);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int sl = 0; sl < 2; sl++)
        for (int io = 0; io < 2; io++) begin
          for (int kd = 0; kd < 4; kd++) pulseCase(kd, io[0], sl[0], s[0]);
          extCase(io[0], sl[0], s[0]);
        end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule